// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block sequences word-program and block-erase operations for a flash-style memory. It also keeps the status byte that software polls. The memory array is abstract: the controller issues program or erase pulse strobes and a verify request, and the array answers with a verify-pass signal in the same cycle. Every operation is entered as a two-cycle command, a setup code followed by a confirm code. After the confirm cycle the controller checks the programming supply, issues a pulse, checks the supply again and then verifies. It repeats the pulse and verify steps until verify passes or a per-operation pulse limit is reached.

A running operation can be suspended. Software can read the suspended state and later resume, and the stored pulse count carries across the suspension. An attempt to program or erase a write-protected boot block is refused before any pulse is issued. The same is true of a low supply level and of a malformed command sequence. All error flags stay set until software issues a clear command.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte reads 0x80 after reset. Bit 7 is 1 while idle, awaiting a confirm code or suspended, and 0 while an operation runs. Bit 0 always reads 0.
- R2: Program is entered as setup 0x40 then confirm 0xD1. Erase is entered as setup 0x20 then confirm 0xD0. After a confirm, the following cycles are: supply check, one pulse cycle (progPulse for program, erasePulse for erase), supply check, verify cycle (verifyReq). A pass in the verify cycle ends the operation.
- R3: If the code in the cycle after a setup is not the matching confirm, bits 7, 5 and 4 are set together, the controller returns to idle and no pulse is issued.
- R4: A block is locked while wpN is 0. With bootTop=1 the locked blocks are the two highest-numbered blocks. With bootTop=0 they are blocks 0 and 1. A confirm aimed at a locked block sets bit 1 and leaves the controller ready with no pulse.
- R5: vppGood is sampled only in the two supply-check cycles. A low sample there sets bit 3 and aborts the operation. A low level in any other cycle has no effect.
- R6: A program whose verify has not passed after MAX_PROG pulses (default 4) sets bit 4 and ends.
- R7: An erase whose verify has not passed after MAX_ERASE pulses (default 8) sets bit 5 and ends.
- R8: Suspend (0xB0) while an operation runs halts it in that cycle with no strobe. It sets bit 7 together with bit 6 for an erase or bit 2 for a program. That bit stays at 1 until resume (0xD0).
- R9: Resume clears the suspend bit and continues with a supply check and a verify. The stored pulse count is kept, so the total number of pulses in the operation never exceeds its limit.
- R10: Bits 5, 4, 3 and 1 are sticky. Only clear-status (0x50), accepted while idle or suspended, resets them. A new operation leaves them unchanged.
- R11: While an operation runs, every code other than suspend is ignored. While idle, codes other than the two setups and clear-status are ignored. While suspended, codes other than resume and clear-status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command code is present this cycle |
| cmdCode | input | 8 | Command code |
| blockAddr | input | BLK_W | Target block, sampled in the confirm cycle |
| wpN | input | 1 | Write protect, 0 locks the boot blocks |
| bootTop | input | 1 | 1 places the boot blocks at the top of the block range |
| vppGood | input | 1 | Programming supply is in range |
| verifyPass | input | 1 | Array verify result for the verify cycle |
| statusByte | output | 8 | Status flags |
| progPulse | output | 1 | Program pulse request to the array |
| erasePulse | output | 1 | Erase pulse request to the array |
| verifyReq | output | 1 | Verify request to the array |

## Verification
The assertions assume that cmdValid, cmdCode and the array answers are stable and defined across each clock edge. They also assume that verifyPass matters only in a verify cycle, and that the stimulus drives no X. The bench changes all inputs only on the falling edge and keeps them at defined values. Directed sequences reach each pulse limit, the suspend and resume path, both lock configurations and both supply-check cycles. A long pseudo-random stretch then mixes every command code with random block, protect, supply and verify levels. A behavioural model predicts the status byte and the strobes in every cycle of that stretch.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
  localparam logic [7:0] CMD_PROG_CONFIRM = 8'hD1;
  localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
  localparam logic [7:0] CMD_RESUME       = 8'hD0;
  localparam logic [7:0] CMD_CLEAR        = 8'h50;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_VPP_PRE,
    ST_PULSE,
    ST_VPP_VFY,
    ST_VERIFY,
    ST_SUSPENDED
  } fscState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startOp;     // confirm accepted, clear pulse count, latch op kind
    logic startErase;  // op kind latched with startOp
    logic incCnt;      // one pulse issued
    logic setSeqErr;   // malformed sequence
    logic setLock;     // locked block targeted
    logic setVppLow;   // supply low at a check point
    logic setVfyFail;  // pulse limit reached without pass
    logic setSusp;     // suspend accepted
    logic clrSusp;     // resume accepted
    logic clrErr;      // clear-status accepted
  } fscStrobe_t;

endpackage

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int MAX_ERASE  = 8,
  parameter int MAX_PROG   = 4,
  localparam int BLK_W   = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int MAX_ALL = (MAX_ERASE > MAX_PROG) ? MAX_ERASE : MAX_PROG,
  localparam int CNT_W   = $clog2(MAX_ALL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fscStrobe_t       strb,
  input  logic             busy,
  input  logic [BLK_W-1:0] blockAddr,
  input  logic             wpN,
  input  logic             bootTop,
  output logic             locked,
  output logic             cntAtMax,
  output logic             opErase,
  output logic [7:0]       statusByte
);

  localparam logic [BLK_W-1:0] TOP_FIRST  = BLK_W'(NUM_BLOCKS - 2);
  localparam logic [BLK_W-1:0] BOT_LAST   = BLK_W'(1);
  localparam logic [CNT_W-1:0] ERASE_LIM  = CNT_W'(MAX_ERASE);
  localparam logic [CNT_W-1:0] PROG_LIM   = CNT_W'(MAX_PROG);

  logic [CNT_W-1:0] pulseCnt;
  logic eraseSusp, progSusp;
  logic eraseFail, progFail, vppLow, lockErr;
  logic inBootRange;

  // boot-block decode
  always_comb begin
    if (bootTop) inBootRange = (blockAddr >= TOP_FIRST);
    else         inBootRange = (blockAddr <= BOT_LAST);
    locked = !wpN && inBootRange;
  end

  assign cntAtMax = opErase ? (pulseCnt >= ERASE_LIM) : (pulseCnt >= PROG_LIM);

  // pulse counter and operation kind
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      opErase  <= 1'b0;
    end else if (strb.startOp) begin
      pulseCnt <= '0;
      opErase  <= strb.startErase;
    end else if (strb.incCnt) begin
      pulseCnt <= pulseCnt + CNT_W'(1);
    end
  end

  // suspend flags: held until resume
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseSusp <= 1'b0;
      progSusp  <= 1'b0;
    end else if (strb.clrSusp) begin
      eraseSusp <= 1'b0;
      progSusp  <= 1'b0;
    end else if (strb.setSusp) begin
      if (opErase) eraseSusp <= 1'b1;
      else         progSusp  <= 1'b1;
    end
  end

  // sticky error flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseFail <= 1'b0;
      progFail  <= 1'b0;
      vppLow    <= 1'b0;
      lockErr   <= 1'b0;
    end else if (strb.clrErr) begin
      eraseFail <= 1'b0;
      progFail  <= 1'b0;
      vppLow    <= 1'b0;
      lockErr   <= 1'b0;
    end else begin
      if (strb.setSeqErr) begin
        eraseFail <= 1'b1;
        progFail  <= 1'b1;
      end
      if (strb.setVfyFail) begin
        if (opErase) eraseFail <= 1'b1;
        else         progFail  <= 1'b1;
      end
      if (strb.setVppLow) vppLow  <= 1'b1;
      if (strb.setLock)   lockErr <= 1'b1;
    end
  end

  assign statusByte = {!busy, eraseSusp, eraseFail, progFail,
                       vppLow, progSusp, lockErr, 1'b0};

endmodule

// File: rtl/fsc_control.sv
module fsc_control
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       locked,
  input  logic       vppGood,
  input  logic       verifyPass,
  input  logic       cntAtMax,
  input  logic       opErase,
  output fscStrobe_t strb,
  output logic       busy,
  output logic       progPulse,
  output logic       erasePulse,
  output logic       verifyReq
);

  fscState_e state, stateNxt;
  logic pendErase, pendEraseNxt;
  logic suspendReq;
  logic [7:0] wantConfirm;

  assign suspendReq  = cmdValid && (cmdCode == CMD_SUSPEND);
  assign wantConfirm = pendErase ? CMD_ERASE_CONFIRM : CMD_PROG_CONFIRM;
  assign busy = (state == ST_VPP_PRE) || (state == ST_PULSE) ||
                (state == ST_VPP_VFY) || (state == ST_VERIFY);

  always_comb begin
    stateNxt     = state;
    pendEraseNxt = pendErase;
    strb         = '0;
    progPulse    = 1'b0;
    erasePulse   = 1'b0;
    verifyReq    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          if (cmdCode == CMD_PROG_SETUP) begin
            stateNxt     = ST_SETUP;
            pendEraseNxt = 1'b0;
          end else if (cmdCode == CMD_ERASE_SETUP) begin
            stateNxt     = ST_SETUP;
            pendEraseNxt = 1'b1;
          end else if (cmdCode == CMD_CLEAR) begin
            strb.clrErr = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (cmdValid) begin
          stateNxt = ST_IDLE;
          if (cmdCode != wantConfirm) begin
            strb.setSeqErr = 1'b1;
          end else if (locked) begin
            strb.setLock = 1'b1;
          end else begin
            strb.startOp    = 1'b1;
            strb.startErase = pendErase;
            stateNxt        = ST_VPP_PRE;
          end
        end
      end
      ST_VPP_PRE, ST_PULSE, ST_VPP_VFY, ST_VERIFY: begin
        if (suspendReq) begin
          strb.setSusp = 1'b1;
          stateNxt     = ST_SUSPENDED;
        end else begin
          case (state)
            ST_VPP_PRE, ST_VPP_VFY: begin
              if (!vppGood) begin
                strb.setVppLow = 1'b1;
                stateNxt       = ST_IDLE;
              end else begin
                stateNxt = (state == ST_VPP_PRE) ? ST_PULSE : ST_VERIFY;
              end
            end
            ST_PULSE: begin
              progPulse   = !opErase;
              erasePulse  = opErase;
              strb.incCnt = 1'b1;
              stateNxt    = ST_VPP_VFY;
            end
            default: begin
              verifyReq = 1'b1;
              if (verifyPass) begin
                stateNxt = ST_IDLE;
              end else if (cntAtMax) begin
                strb.setVfyFail = 1'b1;
                stateNxt        = ST_IDLE;
              end else begin
                stateNxt = ST_PULSE;
              end
            end
          endcase
        end
      end
      ST_SUSPENDED: begin
        if (cmdValid && (cmdCode == CMD_RESUME)) begin
          strb.clrSusp = 1'b1;
          stateNxt     = ST_VPP_VFY;
        end else if (cmdValid && (cmdCode == CMD_CLEAR)) begin
          strb.clrErr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendErase <= 1'b0;
    end else begin
      state     <= stateNxt;
      pendErase <= pendEraseNxt;
    end
  end

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int MAX_ERASE  = 8,
  parameter int MAX_PROG   = 4,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdCode,
  input  logic [BLK_W-1:0] blockAddr,
  input  logic             wpN,
  input  logic             bootTop,
  input  logic             vppGood,
  input  logic             verifyPass,
  output logic [7:0]       statusByte,
  output logic             progPulse,
  output logic             erasePulse,
  output logic             verifyReq
);

  fscStrobe_t strb;
  logic busy, locked, cntAtMax, opErase;

  fsc_control ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .locked     (locked),
    .vppGood    (vppGood),
    .verifyPass (verifyPass),
    .cntAtMax   (cntAtMax),
    .opErase    (opErase),
    .strb       (strb),
    .busy       (busy),
    .progPulse  (progPulse),
    .erasePulse (erasePulse),
    .verifyReq  (verifyReq)
  );

  fsc_datapath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .MAX_ERASE  (MAX_ERASE),
    .MAX_PROG   (MAX_PROG)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .blockAddr  (blockAddr),
    .wpN        (wpN),
    .bootTop    (bootTop),
    .locked     (locked),
    .cntAtMax   (cntAtMax),
    .opErase    (opErase),
    .statusByte (statusByte)
  );

endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [7:0] cmdCode,
  input logic [7:0] statusByte,
  input logic       progPulse,
  input logic       erasePulse,
  input logic       verifyReq
);

  // R1: strobes toward the array only while busy
  assert_busy_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    (progPulse || erasePulse || verifyReq) |-> !statusByte[7]);

  // R2: at most one array request per cycle
  assert_single_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progPulse, erasePulse, verifyReq}));

  // R4: a lock abort issues no pulse in the cycle the flag appears
  assert_lock_no_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[1]) |-> !(progPulse || erasePulse));

  // R8: a suspended state always reads ready
  assert_susp_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] || statusByte[2]) |-> statusByte[7]);

  // R10: erase-fail flag held unless a clear code arrives
  assert_sticky_erase_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] && !(cmdValid && cmdCode == 8'h50)) |=> statusByte[5]);

  // R10: lock flag held unless a clear code arrives
  assert_sticky_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[1] && !(cmdValid && cmdCode == 8'h50)) |=> statusByte[1]);

  // R8: suspend during an erase halts pulsing in the next cycle
  assert_susp_halts_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[6]) |-> !erasePulse);

endmodule

bind flash_status_ctrl fsc_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .statusByte (statusByte),
  .progPulse  (progPulse),
  .erasePulse (erasePulse),
  .verifyReq  (verifyReq)
);

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;

  localparam int NB = 8;
  localparam int LIM_E = 8;
  localparam int LIM_P = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic [2:0] blockAddr = 3'd4;
  logic wpN = 1'b1, bootTop = 1'b0, vppGood = 1'b1, verifyPass = 1'b0;
  logic [7:0] statusByte;
  logic progPulse, erasePulse, verifyReq;

  always #4 clk = ~clk;

  flash_status_ctrl #(.NUM_BLOCKS(NB), .MAX_ERASE(LIM_E), .MAX_PROG(LIM_P)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .blockAddr(blockAddr), .wpN(wpN), .bootTop(bootTop), .vppGood(vppGood),
    .verifyPass(verifyPass), .statusByte(statusByte), .progPulse(progPulse),
    .erasePulse(erasePulse), .verifyReq(verifyReq));

  int vectors = 0, miscompares = 0;
  int progCount = 0, eraseCount = 0;
  bit done = 0;

  // behavioural model: phase names as text for readability
  string mPhase = "idle";
  bit mPendErase = 0, mErase = 0;
  int mPulses = 0;
  bit mES = 0, mEF = 0, mPF = 0, mVL = 0, mPS = 0, mLK = 0;

  function automatic bit modelBusy();
    return (mPhase == "vppA" || mPhase == "pulse" || mPhase == "vppB" || mPhase == "verify");
  endfunction

  function automatic string tagFor(logic [10:0] diff);
    if (diff[10:8] != 0) return "R2";
    if (diff[7]) return "R1";
    if (diff[6] || diff[2]) return "R8";
    if (diff[5]) return "R7";
    if (diff[4]) return "R6";
    if (diff[3]) return "R5";
    if (diff[1]) return "R4";
    return "R1";
  endfunction

  task automatic report(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareNow();
    logic [10:0] expV, actV;
    bit susp, b;
    b = modelBusy();
    susp = b && cmdValid && cmdCode == 8'hB0;
    expV[10] = (mPhase == "pulse") && !susp && !mErase;
    expV[9]  = (mPhase == "pulse") && !susp && mErase;
    expV[8]  = (mPhase == "verify") && !susp;
    expV[7:0] = {!b, mES, mEF, mPF, mVL, mPS, mLK, 1'b0};
    actV = {progPulse, erasePulse, verifyReq, statusByte};
    if (progPulse) progCount++;
    if (erasePulse) eraseCount++;
    report(tagFor(actV ^ expV), int'(actV), int'(expV));
  endtask

  task automatic clearErrs();
    mEF = 0; mPF = 0; mVL = 0; mLK = 0;
  endtask

  task automatic modelUpdate();
    bit lockNow, v;
    int c;
    v = cmdValid;
    c = int'(cmdCode);
    lockNow = !wpN && (bootTop ? (int'(blockAddr) >= NB - 2) : (int'(blockAddr) < 2));
    if (modelBusy() && v && c == 'hB0) begin
      if (mErase) mES = 1; else mPS = 1;
      mPhase = "susp";
      return;
    end
    case (mPhase)
      "idle": if (v) begin
        if (c == 'h40) begin mPhase = "setup"; mPendErase = 0; end
        else if (c == 'h20) begin mPhase = "setup"; mPendErase = 1; end
        else if (c == 'h50) clearErrs();
      end
      "setup": if (v) begin
        mPhase = "idle";
        if (c != (mPendErase ? 'hD0 : 'hD1)) begin mEF = 1; mPF = 1; end
        else if (lockNow) mLK = 1;
        else begin mErase = mPendErase; mPulses = 0; mPhase = "vppA"; end
      end
      "vppA": if (!vppGood) begin mVL = 1; mPhase = "idle"; end else mPhase = "pulse";
      "pulse": begin mPulses++; mPhase = "vppB"; end
      "vppB": if (!vppGood) begin mVL = 1; mPhase = "idle"; end else mPhase = "verify";
      "verify": begin
        if (verifyPass) mPhase = "idle";
        else if (mPulses >= (mErase ? LIM_E : LIM_P)) begin
          if (mErase) mEF = 1; else mPF = 1;
          mPhase = "idle";
        end else mPhase = "pulse";
      end
      "susp": if (v && c == 'hD0) begin mES = 0; mPS = 0; mPhase = "vppB"; end
              else if (v && c == 'h50) clearErrs();
      default: mPhase = "idle";
    endcase
  endtask

  task automatic step(bit v, logic [7:0] c);
    @(negedge clk);
    cmdValid = v;
    cmdCode = c;
    #1;
    compareNow();
    @(posedge clk);
    #1;
    modelUpdate();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic cmd2(logic [7:0] a, logic [7:0] b);
    step(1'b1, a);
    step(1'b1, b);
  endtask

  task automatic runUntilReady();
    for (int i = 0; i < 60; i++) begin
      step(1'b0, 8'h00);
      if (statusByte[7]) break;
    end
  endtask

  task automatic zeroCounts();
    progCount = 0;
    eraseCount = 0;
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1: reset value
    report("R1", int'(statusByte), 'h80);
    report("R1", int'({progPulse, erasePulse, verifyReq}), 0);

    // R2: program passes at first verify
    zeroCounts(); verifyPass = 1;
    cmd2(8'h40, 8'hD1); runUntilReady();
    report("R2", progCount, 1);
    report("R2", int'(statusByte), 'h80);

    // R6: program exhausts its pulse limit
    zeroCounts(); verifyPass = 0;
    cmd2(8'h40, 8'hD1); runUntilReady();
    report("R6", progCount, LIM_P);
    report("R6", int'(statusByte), 'h90);

    // R10: new op keeps errors, clear removes them
    verifyPass = 1;
    cmd2(8'h40, 8'hD1); runUntilReady();
    report("R10", int'(statusByte), 'h90);
    step(1'b1, 8'h50); idle(1);
    report("R10", int'(statusByte), 'h80);

    // R7: erase exhausts its pulse limit
    zeroCounts(); verifyPass = 0;
    cmd2(8'h20, 8'hD0); runUntilReady();
    report("R7", eraseCount, LIM_E);
    report("R7", int'(statusByte), 'hA0);
    step(1'b1, 8'h50);

    // R3: wrong confirm code
    zeroCounts();
    cmd2(8'h20, 8'hFF); idle(3);
    report("R3", int'(statusByte), 'hB0);
    report("R3", eraseCount + progCount, 0);
    // R11: stray code in idle is ignored, busy clear is ignored
    step(1'b1, 8'hD0); idle(2);
    report("R11", int'(statusByte), 'hB0);
    verifyPass = 1;
    cmd2(8'h40, 8'hD1); step(1'b1, 8'h50); runUntilReady();
    report("R11", int'(statusByte), 'hB0);
    step(1'b1, 8'h50);

    // R4: locked blocks, top then bottom configuration
    zeroCounts(); wpN = 0; bootTop = 1; blockAddr = 3'd7;
    cmd2(8'h40, 8'hD1); idle(3);
    report("R4", int'(statusByte), 'h82);
    blockAddr = 3'd6;
    cmd2(8'h20, 8'hD0); idle(3);
    report("R4", progCount + eraseCount, 0);
    step(1'b1, 8'h50);
    bootTop = 0; blockAddr = 3'd0;
    cmd2(8'h40, 8'hD1); idle(3);
    report("R4", int'(statusByte), 'h82);
    step(1'b1, 8'h50);
    blockAddr = 3'd2;
    cmd2(8'h40, 8'hD1); runUntilReady();
    report("R4", progCount, 1);
    wpN = 1; blockAddr = 3'd1;
    cmd2(8'h20, 8'hD0); runUntilReady();
    report("R4", int'(statusByte), 'h80);

    // R5: supply low at first check, then second check, then elsewhere
    zeroCounts(); vppGood = 0; blockAddr = 3'd4;
    cmd2(8'h40, 8'hD1); idle(3);
    report("R5", int'(statusByte), 'h88);
    report("R5", progCount, 0);
    step(1'b1, 8'h50);
    vppGood = 1;
    cmd2(8'h20, 8'hD0); idle(2); vppGood = 0; idle(2);
    report("R5", int'(statusByte), 'h88);
    report("R5", eraseCount, 1);
    vppGood = 1; step(1'b1, 8'h50);
    cmd2(8'h40, 8'hD1); idle(1); vppGood = 0; idle(1); vppGood = 1; runUntilReady();
    report("R5", int'(statusByte), 'h80);

    // R8, R9: erase suspend in a pulse cycle, resume keeps the count
    zeroCounts(); verifyPass = 0;
    cmd2(8'h20, 8'hD0); idle(4);
    step(1'b1, 8'hB0);
    report("R8", int'(statusByte), 'hC0);
    report("R8", eraseCount, 1);
    step(1'b1, 8'h40); idle(3);
    report("R11", int'(statusByte), 'hC0);
    step(1'b1, 8'hD0);
    report("R9", int'(statusByte), 'h00);
    runUntilReady();
    report("R9", eraseCount, LIM_E);
    report("R9", int'(statusByte), 'hA0);
    step(1'b1, 8'h50);

    // R8: program suspend
    verifyPass = 1;
    cmd2(8'h40, 8'hD1); step(1'b1, 8'hB0);
    report("R8", int'(statusByte), 'h84);
    step(1'b1, 8'hD0); runUntilReady();
    report("R8", int'(statusByte), 'h80);

    // mixed pseudo-random stretch against the model
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] code;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      case (lfsr[4:2])
        3'd0: code = 8'h40;
        3'd1: code = 8'h20;
        3'd2: code = 8'hD0;
        3'd3: code = 8'hD1;
        3'd4: code = 8'hB0;
        3'd5: code = 8'h50;
        default: code = 8'hFF;
      endcase
      vppGood = (lfsr[9:7] != 3'd0);
      verifyPass = (lfsr[12:10] == 3'd0);
      wpN = lfsr[13];
      bootTop = lfsr[14];
      blockAddr = lfsr[17:15];
      step(lfsr[0] & lfsr[1], code);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule